// File: doc/BRIEF.md
# Bidirectional Inter-Processor Handshake Flag Unit

This block links two processor subsystems, called side A and side B, with two independent banks of one-bit handshake flags. The A-to-B bank carries flags raised by A for B. The B-to-A bank is its mirror image. A sender sets bits to announce that a message is waiting in shared memory. The flags have no hardware link to that memory. The receiver polls its inbound status and acknowledges to clear the bits. A sender may also withdraw a flag that has not yet been acknowledged.

Each side has a one-cycle register write port and a combinational read port. The register map is the same for both sides:

- Offset 0: writing sets outbound flags.
- Offset 1: writing withdraws outbound flags.
- Offset 2: writing acknowledges, which clears inbound flags.
- Offset 4: holds the receiver's interrupt enables.

Only the lowest-numbered channels can interrupt. These are channels 1 to 4, which are bits 0 to 3. Each interrupt is a level output toward the receiving side.

Top module: `ipc_flag_unit`

## Requirements
- R1: The two banks are independent. A write on one side changes only the outbound bank of that side, through offsets 0 and 1. It also changes the inbound bank of that side, through offset 2. It changes nothing else. A bank with no write aimed at it keeps its value.
- R2: Writing a word to offset 0 sets every outbound flag whose data bit is 1, from the next clock edge. Bits written as 0 leave their flags unchanged.
- R3: Writing a word to offset 2 clears every inbound flag whose data bit is 1. Bits written as 0 have no effect.
- R4: When the sender sets a bit and the receiver acknowledges the same bit in the same cycle, the flag ends up set.
- R5: Writing a word to offset 1 clears the matching outbound flags. This lets the sender withdraw unacknowledged flags.
- R6: Interrupt output bit i is high exactly while inbound flag bit i and enable bit i are both 1, for i = 0 to 3. Enables are written at offset 4 by the receiving side, from data bits 0 to 3.
- R7: Channels 5 to 32 (bits 4 to 31) never raise an interrupt. Reading offset 4 returns the enables in bits 0 to 3 and zeros above.
- R8: The read port is combinational. Offsets 0 and 1 return the outbound flags. Offsets 2 and 3 return the inbound flags. Offset 4 returns the enables. Offsets 5 to 7 return zero.
- R9: After reset, all flags and all enables are zero.
- R10: Side B behaves exactly like side A with the roles swapped. B sets and withdraws the B-to-A flags, A acknowledges them, and the A interrupt outputs reflect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_wr_en | input | 1 | Side A register write strobe |
| a_wr_addr | input | 3 | Side A write offset |
| a_wr_data | input | 32 | Side A write data |
| a_rd_addr | input | 3 | Side A read offset |
| a_rd_data | output | 32 | Side A read data |
| b_wr_en | input | 1 | Side B register write strobe |
| b_wr_addr | input | 3 | Side B write offset |
| b_wr_data | input | 32 | Side B write data |
| b_rd_addr | input | 3 | Side B read offset |
| b_rd_data | output | 32 | Side B read data |
| a_irq | output | 4 | Level interrupts toward side A (B-to-A channels 1 to 4) |
| b_irq | output | 4 | Level interrupts toward side B (A-to-B channels 1 to 4) |

## Verification
Directed steps cover the following cases:
- Set followed by acknowledge.
- An all-zero set, which must leave the flags unchanged.
- A set and an acknowledge of the same bit in one cycle, which separates set-wins from clear-wins.
- Withdrawal by the sender.
- An enable written with all ones, which shows that channels above 4 can neither be enabled nor interrupt.

After these, a seeded random phase drives both sides at once. Each side gets random offsets and sparse random data, so sets, withdrawals and acknowledges often hit the same bank in one cycle. A bench model checks every read offset and both interrupt vectors on every step, which exposes any leak from one bank into the other.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] OFS_SET = 3'd0;
   localparam logic [ADDR_W-1:0] OFS_WDR = 3'd1;
   localparam logic [ADDR_W-1:0] OFS_ACK = 3'd2;
   localparam logic [ADDR_W-1:0] OFS_STS = 3'd3;
   localparam logic [ADDR_W-1:0] OFS_IEN = 3'd4;
endpackage

// File: rtl/ipc_side_port.sv
// Per-side register port: decodes one write strobe into masks and muxes read data.
module ipc_side_port
   import ipc_flag_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int NUM_IRQ = 4
) (
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [NUM_CH-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   input  logic [NUM_CH-1:0]  out_flags,
   input  logic [NUM_CH-1:0]  in_flags,
   input  logic [NUM_IRQ-1:0] ien,
   output logic [NUM_CH-1:0]  set_mask,
   output logic [NUM_CH-1:0]  wdr_mask,
   output logic [NUM_CH-1:0]  ack_mask,
   output logic               ien_we,
   output logic [NUM_CH-1:0]  rd_data
);
   always_comb begin
      set_mask = (wr_en && wr_addr == OFS_SET) ? wr_data : '0;
      wdr_mask = (wr_en && wr_addr == OFS_WDR) ? wr_data : '0;
      ack_mask = (wr_en && wr_addr == OFS_ACK) ? wr_data : '0;
      ien_we   = wr_en && (wr_addr == OFS_IEN);
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         OFS_SET, OFS_WDR: rd_data = out_flags;
         OFS_ACK, OFS_STS: rd_data = in_flags;
         OFS_IEN: begin
            for (int k = 0; k < NUM_IRQ; k++) rd_data[k] = ien[k];
         end
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/ipc_flag_bank.sv
// One direction of handshake flags: sender set/withdraw, receiver ack, IRQ enables.
module ipc_flag_bank #(
   parameter int NUM_CH  = 32,
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CH-1:0]  set_mask,
   input  logic [NUM_CH-1:0]  wdr_mask,
   input  logic [NUM_CH-1:0]  ack_mask,
   input  logic               ien_we,
   input  logic [NUM_IRQ-1:0] ien_wdata,
   output logic [NUM_CH-1:0]  flags,
   output logic [NUM_IRQ-1:0] ien,
   output logic [NUM_IRQ-1:0] irq
);
   logic [NUM_CH-1:0] flags_d;

   // Set dominates any clear arriving in the same cycle.
   always_comb flags_d = (flags & ~(wdr_mask | ack_mask)) | set_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= flags_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien <= '0;
      else if (ien_we) ien <= ien_wdata;
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign irq[i] = flags[i] & ien[i];
   end
endmodule

// File: rtl/ipc_flag_unit.sv
module ipc_flag_unit
   import ipc_flag_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int NUM_IRQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               a_wr_en,
   input  logic [ADDR_W-1:0]  a_wr_addr,
   input  logic [NUM_CH-1:0]  a_wr_data,
   input  logic [ADDR_W-1:0]  a_rd_addr,
   output logic [NUM_CH-1:0]  a_rd_data,
   input  logic               b_wr_en,
   input  logic [ADDR_W-1:0]  b_wr_addr,
   input  logic [NUM_CH-1:0]  b_wr_data,
   input  logic [ADDR_W-1:0]  b_rd_addr,
   output logic [NUM_CH-1:0]  b_rd_data,
   output logic [NUM_IRQ-1:0] a_irq,
   output logic [NUM_IRQ-1:0] b_irq
);
   if (NUM_IRQ < 1 || NUM_IRQ > NUM_CH) begin : g_bad_irq
      $error("ipc_flag_unit: NUM_IRQ must be in 1..NUM_CH");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("ipc_flag_unit: NUM_CH must be positive");
   end

   logic [NUM_CH-1:0]  a_set, a_wdr, a_ack, b_set, b_wdr, b_ack;
   logic               a_ien_we, b_ien_we;
   logic [NUM_CH-1:0]  flags_ab, flags_ba;
   logic [NUM_IRQ-1:0] en_a, en_b;

   ipc_side_port #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_port_a (
      .wr_en(a_wr_en), .wr_addr(a_wr_addr), .wr_data(a_wr_data),
      .rd_addr(a_rd_addr), .out_flags(flags_ab), .in_flags(flags_ba), .ien(en_a),
      .set_mask(a_set), .wdr_mask(a_wdr), .ack_mask(a_ack),
      .ien_we(a_ien_we), .rd_data(a_rd_data));

   ipc_side_port #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_port_b (
      .wr_en(b_wr_en), .wr_addr(b_wr_addr), .wr_data(b_wr_data),
      .rd_addr(b_rd_addr), .out_flags(flags_ba), .in_flags(flags_ab), .ien(en_b),
      .set_mask(b_set), .wdr_mask(b_wdr), .ack_mask(b_ack),
      .ien_we(b_ien_we), .rd_data(b_rd_data));

   // A-to-B: A sets/withdraws, B acknowledges and owns the enables.
   ipc_flag_bank #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_bank_ab (
      .clk(clk), .rst_n(rst_n),
      .set_mask(a_set), .wdr_mask(a_wdr), .ack_mask(b_ack),
      .ien_we(b_ien_we), .ien_wdata(b_wr_data[NUM_IRQ-1:0]),
      .flags(flags_ab), .ien(en_b), .irq(b_irq));

   // B-to-A: mirror image.
   ipc_flag_bank #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_bank_ba (
      .clk(clk), .rst_n(rst_n),
      .set_mask(b_set), .wdr_mask(b_wdr), .ack_mask(a_ack),
      .ien_we(a_ien_we), .ien_wdata(a_wr_data[NUM_IRQ-1:0]),
      .flags(flags_ba), .ien(en_a), .irq(a_irq));
endmodule

// File: rtl/ipc_flag_unit_chk.sv
module ipc_flag_unit_chk
   import ipc_flag_pkg::*;
#(
   parameter int NUM_CH  = 32,
   parameter int NUM_IRQ = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               a_wr_en,
   input logic [ADDR_W-1:0]  a_wr_addr,
   input logic [NUM_CH-1:0]  a_wr_data,
   input logic               b_wr_en,
   input logic [ADDR_W-1:0]  b_wr_addr,
   input logic [NUM_CH-1:0]  b_wr_data,
   input logic [NUM_CH-1:0]  flags_ab,
   input logic [NUM_CH-1:0]  flags_ba,
   input logic [NUM_IRQ-1:0] en_a,
   input logic [NUM_IRQ-1:0] en_b,
   input logic [NUM_IRQ-1:0] a_irq,
   input logic [NUM_IRQ-1:0] b_irq
);
   logic a_set_w, a_wdr_w, a_ack_w, b_set_w, b_wdr_w, b_ack_w;
   assign a_set_w = a_wr_en && a_wr_addr == OFS_SET;
   assign a_wdr_w = a_wr_en && a_wr_addr == OFS_WDR;
   assign a_ack_w = a_wr_en && a_wr_addr == OFS_ACK;
   assign b_set_w = b_wr_en && b_wr_addr == OFS_SET;
   assign b_wdr_w = b_wr_en && b_wr_addr == OFS_WDR;
   assign b_ack_w = b_wr_en && b_wr_addr == OFS_ACK;

   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      a_set_w |=> ((flags_ab & $past(a_wr_data)) == $past(a_wr_data)));

   p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (b_ack_w && !a_set_w) |=> ((flags_ab & $past(b_wr_data)) == '0));

   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_set_w && b_ack_w) |=> ((flags_ab & $past(a_wr_data & b_wr_data)) == $past(a_wr_data & b_wr_data)));

   p_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      a_wdr_w |=> ((flags_ab & $past(a_wr_data)) == '0));

   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_set_w || a_wdr_w || b_ack_w) |=> $stable(flags_ab));

   p_irq_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      b_irq == (flags_ab[NUM_IRQ-1:0] & en_b));

   p_set_ba_r10: assert property (@(posedge clk) disable iff (!rst_n)
      b_set_w |=> ((flags_ba & $past(b_wr_data)) == $past(b_wr_data)));

   p_hold_ba_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_set_w || b_wdr_w || a_ack_w) |=> $stable(flags_ba));

   p_irq_ba_r10: assert property (@(posedge clk) disable iff (!rst_n)
      a_irq == (flags_ba[NUM_IRQ-1:0] & en_a));
endmodule

bind ipc_flag_unit ipc_flag_unit_chk #(.NUM_CH(NUM_CH), .NUM_IRQ(NUM_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
   .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
   .flags_ab(flags_ab), .flags_ba(flags_ba), .en_a(en_a), .en_b(en_b),
   .a_irq(a_irq), .b_irq(b_irq));

// File: tb/ipc_flag_unit_tb.sv
module ipc_flag_unit_tb_top;
   localparam int NCH = 32;
   localparam int NIQ = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_wr_en = 1'b0, b_wr_en = 1'b0;
   logic [2:0] a_wr_addr = '0, b_wr_addr = '0, a_rd_addr = '0, b_rd_addr = '0;
   logic [NCH-1:0] a_wr_data = '0, b_wr_data = '0;
   logic [NCH-1:0] a_rd_data, b_rd_data;
   logic [NIQ-1:0] a_irq, b_irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [NCH-1:0] m_ab = '0, m_ba = '0;
   logic [NIQ-1:0] m_ena = '0, m_enb = '0;

   always #10 clk = ~clk;

   ipc_flag_unit #(.NUM_CH(NCH), .NUM_IRQ(NIQ)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_wr_en(a_wr_en), .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
      .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
      .b_wr_en(b_wr_en), .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data),
      .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
      .a_irq(a_irq), .b_irq(b_irq));

   function automatic logic [NCH-1:0] next_flags(logic [NCH-1:0] f, logic [NCH-1:0] s,
                                                 logic [NCH-1:0] w, logic [NCH-1:0] k);
      return (f & ~(w | k)) | s;
   endfunction

   function automatic logic [NCH-1:0] rd_model(logic [2:0] ofs, logic [NCH-1:0] outb,
                                               logic [NCH-1:0] inb, logic [NIQ-1:0] en);
      logic [NCH-1:0] r;
      r = '0;
      case (ofs)
         3'd0, 3'd1: r = outb;
         3'd2, 3'd3: r = inb;
         3'd4: r[NIQ-1:0] = en;
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic chk(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One write cycle on both sides, model update, then checks of reads and IRQs.
   task automatic step(logic aw, logic [2:0] aa, logic [NCH-1:0] ad,
                       logic bw, logic [2:0] ba, logic [NCH-1:0] bd,
                       logic [2:0] ra, logic [2:0] rb);
      logic [NCH-1:0] as, awd, ak, bs, bwd, bk;
      @(negedge clk);
      a_wr_en = aw; a_wr_addr = aa; a_wr_data = ad;
      b_wr_en = bw; b_wr_addr = ba; b_wr_data = bd;
      as  = (aw && aa == 3'd0) ? ad : '0;
      awd = (aw && aa == 3'd1) ? ad : '0;
      ak  = (aw && aa == 3'd2) ? ad : '0;
      bs  = (bw && ba == 3'd0) ? bd : '0;
      bwd = (bw && ba == 3'd1) ? bd : '0;
      bk  = (bw && ba == 3'd2) ? bd : '0;
      @(posedge clk);
      m_ab = next_flags(m_ab, as, awd, bk);
      m_ba = next_flags(m_ba, bs, bwd, ak);
      if (aw && aa == 3'd4) m_ena = ad[NIQ-1:0];
      if (bw && ba == 3'd4) m_enb = bd[NIQ-1:0];
      #2;
      a_wr_en = 1'b0; b_wr_en = 1'b0;
      a_rd_addr = ra; b_rd_addr = rb;
      #2;
      chk("R8/R1 side A read", a_rd_data, rd_model(ra, m_ab, m_ba, m_ena));
      chk("R8/R10 side B read", b_rd_data, rd_model(rb, m_ba, m_ab, m_enb));
      chk("R6 b_irq", {28'd0, b_irq}, {28'd0, m_ab[NIQ-1:0] & m_enb});
      chk("R10 a_irq", {28'd0, a_irq}, {28'd0, m_ba[NIQ-1:0] & m_ena});
   endtask

   task automatic peek(logic [2:0] ra, logic [2:0] rb);
      a_rd_addr = ra; b_rd_addr = rb;
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;

      // R9: reset state
      for (int o = 0; o < 5; o++) begin
         peek(3'(o), 3'(o));
         chk("R9 reset A", a_rd_data, '0);
         chk("R9 reset B", b_rd_data, '0);
      end
      chk("R9 reset irq", {24'd0, a_irq, b_irq}, '0);

      // R2: set bits 0 and 4
      step(1, 3'd0, 32'h0000_0011, 0, 3'd0, '0, 3'd0, 3'd2);
      chk("R2 set visible to receiver", b_rd_data, 32'h0000_0011);
      peek(3'd3, 3'd0);
      chk("R1 other bank untouched", a_rd_data, 32'h0);
      // R2: zero write
      step(1, 3'd0, 32'h0, 0, 3'd0, '0, 3'd0, 3'd3);
      chk("R2 zero set no effect", b_rd_data, 32'h0000_0011);
      // R6/R7: enable all ones
      step(0, 3'd0, '0, 1, 3'd4, 32'hFFFF_FFFF, 3'd0, 3'd4);
      chk("R7 enable readback upper zero", b_rd_data, 32'h0000_000F);
      chk("R6 irq channel 1 only", {28'd0, b_irq}, 32'h1);
      // R4: set and ack same bit
      step(1, 3'd0, 32'h0000_0001, 1, 3'd2, 32'h0000_0001, 3'd0, 3'd2);
      chk("R4 set wins", b_rd_data, 32'h0000_0011);
      // R3: ack bit 4, zero ack no effect
      step(0, 3'd0, '0, 1, 3'd2, 32'h0000_0010, 3'd0, 3'd2);
      chk("R3 ack clears", b_rd_data, 32'h0000_0001);
      step(0, 3'd0, '0, 1, 3'd2, 32'h0, 3'd0, 3'd2);
      chk("R3 zero ack no effect", b_rd_data, 32'h0000_0001);
      // R5: withdraw
      step(1, 3'd1, 32'h0000_0001, 0, 3'd0, '0, 3'd0, 3'd2);
      chk("R5 withdraw", b_rd_data, 32'h0);
      chk("R6 irq drops", {28'd0, b_irq}, 32'h0);
      // R7: high channel with enable never interrupts
      step(1, 3'd0, 32'hFFFF_FFF0, 0, 3'd0, '0, 3'd0, 3'd2);
      chk("R7 no irq above channel 4", {28'd0, b_irq}, 32'h0);
      // R10: mirror direction
      step(1, 3'd4, 32'h0000_0008, 1, 3'd0, 32'h0000_0008, 3'd2, 3'd0);
      chk("R10 B set seen by A", a_rd_data, 32'h0000_0008);
      chk("R10 a_irq channel 4", {28'd0, a_irq}, 32'h8);
      step(1, 3'd2, 32'h0000_0008, 0, 3'd0, '0, 3'd2, 3'd0);
      chk("R10 A ack clears", a_rd_data, 32'h0);
      // R8: unused offsets read zero
      peek(3'd7, 3'd5);
      chk("R8 unused offset A", a_rd_data, '0);
      chk("R8 unused offset B", b_rd_data, '0);

      // random phase
      void'($urandom(32'd1234));
      for (int n = 0; n < 400; n++) begin
         step($urandom % 2 == 0, 3'($urandom % 6), $urandom & $urandom,
              $urandom % 2 == 0, 3'($urandom % 6), $urandom & $urandom,
              3'($urandom % 8), 3'($urandom % 8));
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule